// File: doc/BRIEF.md
# Vector Prefix Field Decoder

This block sits in an instruction decode pipeline at the point where a lead byte of 0xC4 or 0xC5 has been found. It gets that byte, the two bytes that follow it, the immediate byte of the instruction and two attributes of the opcode. From these it first decides whether the bytes form a vector-extension prefix or are an ordinary opcode. It then takes the prefix apart into the fields the rest of the decoder needs.

Those fields are the opcode map, the implied SIMD prefix and the W and L bits. The register-extension bits and the extra source register are stored inverted, and the block returns them in true form. It also forms an index for the next lookup table and an effective REX value, masked by the bits the opcode accepts. It chooses between the 128-bit and 256-bit register class and pulls a fourth register number out of the immediate byte. It reports how many bytes the prefix used up, so that the instruction length stays correct.

All results are registered, with a latency of one cycle. A new set of bytes can be accepted every cycle.

Top module: `vex_prefix_decoder`

## Requirements
- R1: While reset is high and after it falls, the outputs are all zero, with `out_valid` low, until the first accepted input.
- R2: When `in_valid` is high, the decoded result appears on the next rising edge with `out_valid` high. When `in_valid` is low, `out_valid` is low on the next edge and every other output keeps its value.
- R3: If the lead byte is neither 0xC4 nor 0xC5, `is_vex` is 0, `map_err` is 0, `consumed` is 0 and all field outputs are zero.
- R4: With `mode64` low, a lead byte of 0xC4 or 0xC5 starts a prefix only when `byte1[7:6]` is 2'b11. Otherwise the result is the same as for a non-candidate byte (R3). With `mode64` high, the mod bits are not examined.
- R5: In the three-byte form (lead byte 0xC4), the map is `byte1[4:0]`. A map of 0 or above 3 sets `map_err`, clears `is_vex`, reports `consumed` = 3 and zeroes all field outputs.
- R6: `tab_idx` is {`byte2[1:0]`, `byte1[1:0]`} in the three-byte form and {`byte1[1:0]`, 2'b01} in the two-byte form. `simd_pfx` carries the pp bits and `map_sel` the low two map bits (1 in the two-byte form).
- R7: A valid prefix reports `consumed` = 3 for the three-byte form and 2 for the two-byte form (lead byte 0xC5).
- R8: `w_bit` is `byte2[7]` in the three-byte form and 0 in the two-byte form. `l_bit` is bit 2 of the last prefix byte (`byte2` or `byte1` respectively).
- R9: `vreg` is the bitwise inverse of bits 6:3 of the last prefix byte.
- R10: With `mode64` high, `eff_rex` = {W, R, X, B} & `rex_allow`. R, X and B are the inverses of `byte1[7]`, `byte1[6]` and `byte1[5]` in the three-byte form. The two-byte form gives R = ~`byte1[7]` and X = B = 0. Bit 3 of `rex_allow` gates W and bit 0 gates B. With `mode64` low, `eff_rex` is 0.
- R11: `wide_sel` (1 selects the 256-bit class) is high only for a valid prefix with L = 1 and `wide_ok` high.
- R12: For a valid prefix, `imm_reg` is `imm_byte[7:4]` with `mode64` high and {0, `imm_byte[6:4]`} with it low. It is 0 when there is no valid prefix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input bytes are valid this cycle |
| mode64 | input | 1 | Processor is in 64-bit mode |
| lead_byte | input | 8 | Candidate lead byte |
| byte1 | input | 8 | First byte after the lead byte |
| byte2 | input | 8 | Second byte after the lead byte |
| imm_byte | input | 8 | Immediate byte of the instruction |
| rex_allow | input | 4 | Per-opcode mask of allowed W,R,X,B bits |
| wide_ok | input | 1 | Opcode allows 256-bit operation |
| out_valid | output | 1 | Result registers were loaded on this edge |
| is_vex | output | 1 | Bytes form a valid prefix |
| map_err | output | 1 | Reserved map value in the three-byte form |
| consumed | output | 2 | Prefix bytes used up (0, 2 or 3) |
| tab_idx | output | 4 | Index for the next lookup table |
| simd_pfx | output | 2 | Implied SIMD prefix (pp) |
| map_sel | output | 2 | Opcode map select |
| w_bit | output | 1 | W bit |
| l_bit | output | 1 | L bit |
| vreg | output | 4 | Extra source register, in true form |
| eff_rex | output | 4 | Effective REX {W,R,X,B} |
| wide_sel | output | 1 | 256-bit register class selected |
| imm_reg | output | 4 | Register number taken from the immediate byte |

## Verification
The bench covers the mod-bit check outside 64-bit mode. A design that skipped it would take a legacy opcode as a prefix and report two or three bytes used up. A design that applied it in 64-bit mode would reject a valid two-byte prefix. The bench also uses map values 0, 3, 4 and 31, which catch an off-by-one in the reserved range, and prefixes whose inverted fields are all ones and all zeros, which catch a missing inversion of R, X, B or vvvv. Partial `rex_allow` masks, 64-bit versus other modes for the REX value and the immediate-register width, and L without `wide_ok` find a mask or class choice that ignores one of its inputs.

// File: rtl/vexdec_pkg.sv
package vexdec_pkg;

    parameter int BYTE_W    = 8;
    parameter int REG_W     = 4;
    parameter int MAP_W     = 5;
    parameter int MAP_SEL_W = 2;
    parameter int PP_W      = 2;
    parameter int REX_W     = 4;
    parameter int CNT_W     = 2;
    localparam int IDX_W    = PP_W + MAP_SEL_W;

    localparam logic [BYTE_W-1:0] LEAD_THREE = 8'hC4;
    localparam logic [BYTE_W-1:0] LEAD_TWO   = 8'hC5;
    localparam logic [1:0]        MOD_REG    = 2'b11;

    typedef enum logic [1:0] {
        FORM_NONE  = 2'd0,
        FORM_TWO   = 2'd1,
        FORM_THREE = 2'd2
    } vex_form_e;

    typedef struct packed {
        logic                 w;
        logic                 r;
        logic                 x;
        logic                 b;
        logic                 l;
        logic [REG_W-1:0]     vreg;
        logic [PP_W-1:0]      pp;
        logic [MAP_W-1:0]     map;
    } vex_fields_t;

    typedef struct packed {
        logic                 is_vex;
        logic                 map_err;
        logic [CNT_W-1:0]     consumed;
        logic [IDX_W-1:0]     tab_idx;
        logic [PP_W-1:0]      pp;
        logic [MAP_SEL_W-1:0] map_sel;
        logic                 w;
        logic                 l;
        logic [REG_W-1:0]     vreg;
        logic [REX_W-1:0]     rex;
        logic                 wide;
        logic [REG_W-1:0]     imm_reg;
    } vex_result_t;

    function automatic logic map_reserved(input logic [MAP_W-1:0] m,
                                          input int unsigned max_map);
        return (m == '0) || (int'(m) > int'(max_map));
    endfunction

    function automatic logic [CNT_W-1:0] form_len(input vex_form_e f);
        case (f)
            FORM_THREE: return CNT_W'(3);
            FORM_TWO:   return CNT_W'(2);
            default:    return '0;
        endcase
    endfunction

endpackage

// File: rtl/vexdec_classify.sv
module vexdec_classify
    import vexdec_pkg::*;
(
    input  logic              mode64,
    input  logic [BYTE_W-1:0] lead_byte,
    input  logic [BYTE_W-1:0] byte1,
    output vex_form_e         form
);
    logic is_three;
    logic is_two;
    logic mod_pass;

    always_comb begin
        is_three = (lead_byte == LEAD_THREE);
        is_two   = (lead_byte == LEAD_TWO);
        // Outside 64-bit mode the next byte must look like a register-form
        // ModRM, otherwise the lead byte is an ordinary opcode.
        mod_pass = mode64 || (byte1[BYTE_W-1 -: 2] == MOD_REG);
        if (is_three && mod_pass)
            form = FORM_THREE;
        else if (is_two && mod_pass)
            form = FORM_TWO;
        else
            form = FORM_NONE;
    end
endmodule

// File: rtl/vexdec_fields.sv
module vexdec_fields
    import vexdec_pkg::*;
#(
    parameter int unsigned MAX_MAP = 3
) (
    input  vex_form_e         form,
    input  logic [BYTE_W-1:0] byte1,
    input  logic [BYTE_W-1:0] byte2,
    output vex_fields_t       fields,
    output logic              map_err
);
    logic [BYTE_W-1:0] last_byte;
    logic [REG_W-1:0]  vreg_true;

    assign last_byte = (form == FORM_THREE) ? byte2 : byte1;

    // The extra source register is stored one's-complemented, bits 6:3.
    for (genvar gi = 0; gi < REG_W; gi++) begin : g_vinv
        assign vreg_true[gi] = ~last_byte[3 + gi];
    end

    always_comb begin
        fields      = '0;
        fields.l    = last_byte[2];
        fields.vreg = vreg_true;
        fields.pp   = last_byte[PP_W-1:0];
        fields.r    = ~byte1[7];
        if (form == FORM_THREE) begin
            fields.x   = ~byte1[6];
            fields.b   = ~byte1[5];
            fields.map = byte1[MAP_W-1:0];
            fields.w   = byte2[7];
        end else begin
            fields.x   = 1'b0;
            fields.b   = 1'b0;
            fields.map = MAP_W'(1);
            fields.w   = 1'b0;
        end
        map_err = (form == FORM_THREE) && map_reserved(byte1[MAP_W-1:0], MAX_MAP);
    end
endmodule

// File: rtl/vexdec_resolve.sv
module vexdec_resolve
    import vexdec_pkg::*;
(
    input  vex_form_e         form,
    input  vex_fields_t       fields,
    input  logic              map_err,
    input  logic              mode64,
    input  logic [REX_W-1:0]  rex_allow,
    input  logic              wide_ok,
    input  logic [BYTE_W-1:0] imm_byte,
    output vex_result_t       result
);
    logic             good;
    logic [REX_W-1:0] raw_rex;
    logic [REG_W-1:0] imm_mask;

    assign good     = (form != FORM_NONE) && !map_err;
    assign raw_rex  = {fields.w, fields.r, fields.x, fields.b};
    // Only eight registers are reachable outside 64-bit mode.
    assign imm_mask = mode64 ? {REG_W{1'b1}} : {1'b0, {(REG_W-1){1'b1}}};

    always_comb begin
        result          = '0;
        result.map_err  = map_err;
        result.consumed = form_len(form);
        if (good) begin
            result.is_vex  = 1'b1;
            result.pp      = fields.pp;
            result.map_sel = fields.map[MAP_SEL_W-1:0];
            result.tab_idx = {fields.pp, fields.map[MAP_SEL_W-1:0]};
            result.w       = fields.w;
            result.l       = fields.l;
            result.vreg    = fields.vreg;
            result.rex     = mode64 ? (raw_rex & rex_allow) : '0;
            result.wide    = fields.l & wide_ok;
            result.imm_reg = imm_byte[BYTE_W-1 -: REG_W] & imm_mask;
        end
    end
endmodule

// File: rtl/vex_prefix_decoder.sv
module vex_prefix_decoder
    import vexdec_pkg::*;
#(
    parameter int unsigned MAX_MAP = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic                 mode64,
    input  logic [BYTE_W-1:0]    lead_byte,
    input  logic [BYTE_W-1:0]    byte1,
    input  logic [BYTE_W-1:0]    byte2,
    input  logic [BYTE_W-1:0]    imm_byte,
    input  logic [REX_W-1:0]     rex_allow,
    input  logic                 wide_ok,
    output logic                 out_valid,
    output logic                 is_vex,
    output logic                 map_err,
    output logic [CNT_W-1:0]     consumed,
    output logic [IDX_W-1:0]     tab_idx,
    output logic [PP_W-1:0]      simd_pfx,
    output logic [MAP_SEL_W-1:0] map_sel,
    output logic                 w_bit,
    output logic                 l_bit,
    output logic [REG_W-1:0]     vreg,
    output logic [REX_W-1:0]     eff_rex,
    output logic                 wide_sel,
    output logic [REG_W-1:0]     imm_reg
);
    vex_form_e   form;
    vex_fields_t fields;
    logic        fld_err;
    vex_result_t comb_res;
    vex_result_t res_q;
    logic        valid_q;

    vexdec_classify u_classify (
        .mode64    (mode64),
        .lead_byte (lead_byte),
        .byte1     (byte1),
        .form      (form)
    );

    vexdec_fields #(.MAX_MAP(MAX_MAP)) u_fields (
        .form    (form),
        .byte1   (byte1),
        .byte2   (byte2),
        .fields  (fields),
        .map_err (fld_err)
    );

    vexdec_resolve u_resolve (
        .form      (form),
        .fields    (fields),
        .map_err   (fld_err),
        .mode64    (mode64),
        .rex_allow (rex_allow),
        .wide_ok   (wide_ok),
        .imm_byte  (imm_byte),
        .result    (comb_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= in_valid;
            if (in_valid)
                res_q <= comb_res;
        end
    end

    assign out_valid = valid_q;
    assign is_vex    = res_q.is_vex;
    assign map_err   = res_q.map_err;
    assign consumed  = res_q.consumed;
    assign tab_idx   = res_q.tab_idx;
    assign simd_pfx  = res_q.pp;
    assign map_sel   = res_q.map_sel;
    assign w_bit     = res_q.w;
    assign l_bit     = res_q.l;
    assign vreg      = res_q.vreg;
    assign eff_rex   = res_q.rex;
    assign wide_sel  = res_q.wide;
    assign imm_reg   = res_q.imm_reg;
endmodule

// File: rtl/vex_prefix_decoder_chk.sv
module vex_prefix_decoder_chk
    import vexdec_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic                 mode64,
    input logic                 out_valid,
    input logic                 is_vex,
    input logic                 map_err,
    input logic [CNT_W-1:0]     consumed,
    input logic [IDX_W-1:0]     tab_idx,
    input logic                 w_bit,
    input logic                 l_bit,
    input logic [REX_W-1:0]     eff_rex,
    input logic                 wide_sel
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);                                               // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);                                             // R2
    AST_NO_PREFIX_NO_LEN: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !is_vex && !map_err) |-> (consumed == '0));              // R3
    AST_BAD_MAP_LEN: assert property (@(posedge clk) disable iff (rst)
        (out_valid && map_err) |-> (consumed == CNT_W'(3) && !is_vex));        // R5
    AST_TWO_BYTE_IDX: assert property (@(posedge clk) disable iff (rst)
        (out_valid && is_vex && consumed == CNT_W'(2)) |-> (tab_idx[1:0] == 2'b01)); // R6
    AST_PREFIX_LEN: assert property (@(posedge clk) disable iff (rst)
        (out_valid && is_vex) |-> (consumed == CNT_W'(2) || consumed == CNT_W'(3))); // R7
    AST_TWO_BYTE_NO_W: assert property (@(posedge clk) disable iff (rst)
        (out_valid && is_vex && consumed == CNT_W'(2)) |-> !w_bit);           // R8
    AST_REX_OUTSIDE64: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !mode64) |=> (eff_rex == '0));                            // R10
    AST_WIDE_NEEDS_L: assert property (@(posedge clk) disable iff (rst)
        wide_sel |-> (l_bit && is_vex));                                       // R11
endmodule

bind vex_prefix_decoder vex_prefix_decoder_chk u_chk (.*);

// File: tb/vex_prefix_decoder_test.sv
module vex_prefix_decoder_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic       mode64;
    logic [7:0] lead_byte, byte1, byte2, imm_byte;
    logic [3:0] rex_allow;
    logic       wide_ok;
    logic       out_valid, is_vex, map_err, w_bit, l_bit, wide_sel;
    logic [1:0] consumed, simd_pfx, map_sel;
    logic [3:0] tab_idx, vreg, eff_rex, imm_reg;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    vex_prefix_decoder uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode64(mode64),
        .lead_byte(lead_byte), .byte1(byte1), .byte2(byte2), .imm_byte(imm_byte),
        .rex_allow(rex_allow), .wide_ok(wide_ok),
        .out_valid(out_valid), .is_vex(is_vex), .map_err(map_err),
        .consumed(consumed), .tab_idx(tab_idx), .simd_pfx(simd_pfx),
        .map_sel(map_sel), .w_bit(w_bit), .l_bit(l_bit), .vreg(vreg),
        .eff_rex(eff_rex), .wide_sel(wide_sel), .imm_reg(imm_reg)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drive one input set at the falling edge, sample after the next rising edge.
    task automatic apply(input logic m64, input logic [7:0] ld, input logic [7:0] b1,
                         input logic [7:0] b2, input logic [7:0] imm,
                         input logic [3:0] allow, input logic wok);
        @(negedge clk);
        in_valid = 1'b1; mode64 = m64; lead_byte = ld; byte1 = b1; byte2 = b2;
        imm_byte = imm; rex_allow = allow; wide_ok = wok;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_none(input string req);
        chk(req, "out_valid", out_valid, 1);
        chk(req, "is_vex", is_vex, 0);
        chk(req, "map_err", map_err, 0);
        chk(req, "consumed", consumed, 0);
        chk(req, "tab_idx", tab_idx, 0);
        chk(req, "vreg", vreg, 0);
        chk(req, "imm_reg", imm_reg, 0);
    endtask

    task automatic t_reset;
        rst = 1'b1; in_valid = 1'b0; mode64 = 1'b0; lead_byte = '0; byte1 = '0;
        byte2 = '0; imm_byte = '0; rex_allow = '0; wide_ok = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "out_valid", out_valid, 0);
        chk("R1", "consumed", consumed, 0);
        chk("R1", "tab_idx", tab_idx, 0);
        chk("R1", "eff_rex", eff_rex, 0);
    endtask

    task automatic t_three_byte_long;
        // b1 = 011_00010: R=1 X=0 B=0 map 2; b2 = 1_0101_1_01: W=1 vvvv~=A L=1 pp=1
        apply(1'b1, 8'hC4, 8'h62, 8'hAD, 8'hF3, 4'hF, 1'b1);
        chk("R7", "consumed", consumed, 3);
        chk("R6", "tab_idx", tab_idx, 6);
        chk("R6", "simd_pfx", simd_pfx, 1);
        chk("R6", "map_sel", map_sel, 2);
        chk("R8", "w_bit", w_bit, 1);
        chk("R8", "l_bit", l_bit, 1);
        chk("R9", "vreg", vreg, 4'hA);
        chk("R10", "eff_rex", eff_rex, 4'hC);
        chk("R11", "wide_sel", wide_sel, 1);
        chk("R12", "imm_reg", imm_reg, 4'hF);
    endtask

    task automatic t_two_byte_compat;
        // 32-bit mode, b1 = 1_1100_0_11: mod bits 11 so prefix is taken
        apply(1'b0, 8'hC5, 8'hE3, 8'h00, 8'hF0, 4'hF, 1'b1);
        chk("R4", "is_vex", is_vex, 1);
        chk("R7", "consumed", consumed, 2);
        chk("R6", "tab_idx", tab_idx, 4'hD);
        chk("R6", "map_sel", map_sel, 1);
        chk("R8", "w_bit", w_bit, 0);
        chk("R8", "l_bit", l_bit, 0);
        chk("R9", "vreg", vreg, 3);
        chk("R10", "eff_rex", eff_rex, 0);
        chk("R11", "wide_sel", wide_sel, 0);
        chk("R12", "imm_reg", imm_reg, 7);
    endtask

    task automatic t_three_byte_compat;
        // 32-bit mode, b1 = 111_00001 map 1; b2 = 0_1111_1_00
        apply(1'b0, 8'hC4, 8'hE1, 8'h7C, 8'hA5, 4'hF, 1'b1);
        chk("R7", "consumed", consumed, 3);
        chk("R6", "tab_idx", tab_idx, 1);
        chk("R9", "vreg", vreg, 0);
        chk("R10", "eff_rex", eff_rex, 0);
        chk("R11", "wide_sel", wide_sel, 1);
        chk("R12", "imm_reg", imm_reg, 2);
    endtask

    task automatic t_legacy;
        apply(1'b0, 8'hC4, 8'h40, 8'hFF, 8'hFF, 4'hF, 1'b1);
        expect_none("R4");
        apply(1'b0, 8'hC5, 8'hBF, 8'hFF, 8'hFF, 4'hF, 1'b1);
        expect_none("R4");
        apply(1'b1, 8'h0F, 8'hC1, 8'h7C, 8'hFF, 4'hF, 1'b1);
        expect_none("R3");
    endtask

    task automatic t_two_byte_long;
        // 64-bit mode, mod bits 00 still a prefix; b1 = 0_0000_1_00
        apply(1'b1, 8'hC5, 8'h04, 8'h00, 8'h30, 4'h4, 1'b0);
        chk("R4", "is_vex", is_vex, 1);
        chk("R7", "consumed", consumed, 2);
        chk("R6", "tab_idx", tab_idx, 1);
        chk("R9", "vreg", vreg, 4'hF);
        chk("R10", "eff_rex", eff_rex, 4'h4);
        chk("R11", "wide_sel", wide_sel, 0);
        chk("R12", "imm_reg", imm_reg, 3);
        apply(1'b1, 8'hC5, 8'h04, 8'h00, 8'h30, 4'h0, 1'b1);
        chk("R10", "eff_rex masked", eff_rex, 0);
        chk("R11", "wide_sel", wide_sel, 1);
    endtask

    task automatic t_rex_mask;
        // b1 = 000_00011: R=X=B=1 map 3; b2 = 1_0000_0_10: W=1 pp=2
        apply(1'b1, 8'hC4, 8'h03, 8'h82, 8'h00, 4'hA, 1'b1);
        chk("R5", "map 3 accepted", is_vex, 1);
        chk("R6", "tab_idx", tab_idx, 4'hB);
        chk("R10", "eff_rex", eff_rex, 4'hA);
        chk("R11", "wide_sel", wide_sel, 0);
    endtask

    task automatic t_reserved_map;
        apply(1'b1, 8'hC4, 8'h04, 8'hAD, 8'hF3, 4'hF, 1'b1);
        chk("R5", "map_err (4)", map_err, 1);
        chk("R5", "is_vex", is_vex, 0);
        chk("R5", "consumed", consumed, 3);
        chk("R5", "vreg", vreg, 0);
        chk("R5", "eff_rex", eff_rex, 0);
        apply(1'b1, 8'hC4, 8'h1F, 8'hAD, 8'hF3, 4'hF, 1'b1);
        chk("R5", "map_err (31)", map_err, 1);
        apply(1'b0, 8'hC4, 8'hE0, 8'hAD, 8'hF3, 4'hF, 1'b1);
        chk("R5", "map_err (0)", map_err, 1);
        chk("R5", "tab_idx", tab_idx, 0);
    endtask

    task automatic t_idle_hold;
        apply(1'b1, 8'hC4, 8'h62, 8'hAD, 8'hF3, 4'hF, 1'b1);
        @(negedge clk);
        lead_byte = 8'h0F;
        @(negedge clk);
        chk("R2", "out_valid idle", out_valid, 0);
        chk("R2", "tab_idx held", tab_idx, 6);
        chk("R2", "consumed held", consumed, 3);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_three_byte_long();
        t_two_byte_compat();
        t_three_byte_compat();
        t_legacy();
        t_two_byte_long();
        t_rex_mask();
        t_reserved_map();
        t_idle_hold();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule